// File: doc/BRIEF.md
# Windowed Raster Readout Sequencer

This block drives the readout of a rolling-shutter pixel array. It produces a pixel clock at half the master clock rate, a frame strobe, a line strobe, and the physical row and column address to read for every pixel slot. The window is programmable by start position, height and width. The window's coordinates are relative to the first light-sensitive pixel: the array has a band of optically black rows at the top and a band of optically black columns at the left, and the block adds their size to every address. A counter-derived test value stands in for pixel data.

Each frame runs as follows. A start blank comes first, with a length set by a divider setting. The active rows follow, each one separated by a horizontal blank. An end blank comes next, the same length as the start blank. Last comes a vertical blank that lasts a whole number of row times. Five mode bits set the readout: row mirror, column mirror, row skip, column skip and a 2x pixel repeat. The mode bits reorder, thin out or duplicate the addresses. All settings are copied into working registers only at the start of a frame.

Top module: `pix_raster_gen`

## Requirements
- R1: While `rst` is high, `pix_clk` is 1 and `frame_valid`, `line_valid`, `row_addr`, `col_addr` and `pix_data` are all 0.
- R2: `pix_clk` inverts on every master clock. The strobes, addresses and data change only on the edge where `pix_clk` goes from 1 to 0, so they are stable for the whole cycle in which `pix_clk` is 1. One pixel slot lasts two master clocks.
- R3: A frame is: FB = 3*(`cfg_clk_div`+2) slots with `frame_valid` high and `line_valid` low; then N rows, each with A slots of `line_valid` high and, between rows, `cfg_hblank` slots of `line_valid` low; then FB more slots of that kind; then `cfg_vblank`*(A+`cfg_hblank`) slots with `frame_valid` low. `line_valid` is never high while `frame_valid` is low.
- R4: For output row r and pixel p, with no mode bits set, `row_addr` = BLACK_ROWS+`cfg_row_start`+r and `col_addr` = BLACK_COLS+`cfg_col_start`+p. Here N = `cfg_height` and A = `cfg_width`.
- R5: Mode bit 2 (row skip) makes N = `cfg_height`/2 (rounded down) and the row step 2. Mode bit 3 (column skip) halves the column count and makes the column step 2. A count that comes out as 0 is used as 1.
- R6: Mode bit 4 (repeat) outputs each column address on two consecutive slots, so A is twice the column count.
- R7: Mode bit 0 (row mirror) reads the window's rows last to first.
- R8: Mode bit 1 (column mirror) reads the window's columns last to first within each row.
- R9: Any address beyond the array is replaced by ARRAY_ROWS-1 or ARRAY_COLS-1.
- R10: Settings are taken only at the first slot of a frame. Changes made during a frame do not affect that frame.
- R11: `pix_data` equals (`row_addr`+`col_addr`) modulo 2^DATA_W while `line_valid` is high. `pix_data`, `row_addr` and `col_addr` are 0 while it is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_row_start | input | ROW_W | First window row, relative to the first light-sensitive row |
| cfg_col_start | input | COL_W | First window column, relative to the first light-sensitive column |
| cfg_height | input | ROW_W | Window height in rows |
| cfg_width | input | COL_W | Window width in columns |
| cfg_hblank | input | HB_W | Slots of horizontal blank between rows |
| cfg_vblank | input | VB_W | Row times of vertical blank |
| cfg_clk_div | input | DIV_W | Divider setting that scales the start and end blanks |
| cfg_mode | input | 5 | Mode bits {repeat, col skip, row skip, col mirror, row mirror} |
| pix_clk | output | 1 | Pixel clock, half the master rate |
| frame_valid | output | 1 | Frame strobe |
| line_valid | output | 1 | Line strobe |
| row_addr | output | ROW_W | Physical row being read |
| col_addr | output | COL_W | Physical column being read |
| pix_data | output | DATA_W | Test pattern value |

## Verification
The bench runs windows that leave out the horizontal blank, the vertical blank or both. A design that counts a zero-length blank as one slot, or as a full wrap of its counter, loses alignment with the reference slot by slot. Odd heights and widths under skip, and a zero count after halving, expose halving that rounds the wrong way or produces empty frames. Mirror mode is run together with skip, with repeat and with a window that runs past the array edge. A design that mirrors after clamping, or that forgets the black band, gives wrong addresses on the first row. Settings are also changed twice inside one frame. A design that takes settings at any moment other than frame start alters the frame in progress.

// File: rtl/rg_pkg.sv
package rg_pkg;

  typedef enum logic [2:0] {
    ST_FSTART = 3'd0,
    ST_ACT    = 3'd1,
    ST_HBLK   = 3'd2,
    ST_FEND   = 3'd3,
    ST_VBLK   = 3'd4
  } rg_state_e;

  typedef struct packed {
    logic zoom;
    logic col_skip;
    logic row_skip;
    logic col_mirror;
    logic row_mirror;
  } rg_mode_t;

endpackage

// File: rtl/rg_shadow.sv
module rg_shadow
  import rg_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int COL_W = 10,
  parameter int HB_W  = 10,
  parameter int VB_W  = 10,
  parameter int DIV_W = 4,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             load,
  input  logic [ROW_W-1:0] in_row_start,
  input  logic [COL_W-1:0] in_col_start,
  input  logic [ROW_W-1:0] in_height,
  input  logic [COL_W-1:0] in_width,
  input  logic [HB_W-1:0]  in_hblank,
  input  logic [VB_W-1:0]  in_vblank,
  input  logic [DIV_W-1:0] in_div,
  input  rg_mode_t         in_mode,
  output logic [ROW_W-1:0] sh_row_start,
  output logic [COL_W-1:0] sh_col_start,
  output logic [VB_W-1:0]  sh_vblank,
  output rg_mode_t         sh_mode,
  output logic [ROW_W-1:0] n_rows,
  output logic [COL_W-1:0] n_cols,
  output logic [CNT_W-1:0] act_len,
  output logic [CNT_W-1:0] hb_len,
  output logic [CNT_W-1:0] fb_len,
  output logic [CNT_W-1:0] row_time
);

  logic [ROW_W-1:0] sh_height;
  logic [COL_W-1:0] sh_width;
  logic [HB_W-1:0]  sh_hblank;
  logic [DIV_W-1:0] sh_div;
  logic [ROW_W-1:0] h_eff;
  logic [COL_W-1:0] w_eff;

  // Working copies change only when the sequencer wraps to a new frame
  always_ff @(posedge clk) begin
    if (load) begin
      sh_row_start <= in_row_start;
      sh_col_start <= in_col_start;
      sh_height    <= in_height;
      sh_width     <= in_width;
      sh_hblank    <= in_hblank;
      sh_vblank    <= in_vblank;
      sh_div       <= in_div;
      sh_mode      <= in_mode;
    end
  end

  always_comb begin
    h_eff    = sh_mode.row_skip ? (sh_height >> 1) : sh_height;
    w_eff    = sh_mode.col_skip ? (sh_width >> 1) : sh_width;
    n_rows   = (h_eff == '0) ? ROW_W'(1) : h_eff;
    n_cols   = (w_eff == '0) ? COL_W'(1) : w_eff;
    act_len  = sh_mode.zoom ? (CNT_W'(n_cols) << 1) : CNT_W'(n_cols);
    hb_len   = CNT_W'(sh_hblank);
    fb_len   = CNT_W'(3) * (CNT_W'(sh_div) + CNT_W'(2));
    row_time = act_len + hb_len;
  end

endmodule

// File: rtl/rg_seq.sv
module rg_seq
  import rg_pkg::*;
#(
  parameter int ROW_W = 9,
  parameter int VB_W  = 10,
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic [ROW_W-1:0] n_rows,
  input  logic [CNT_W-1:0] act_len,
  input  logic [CNT_W-1:0] hb_len,
  input  logic [CNT_W-1:0] fb_len,
  input  logic [CNT_W-1:0] row_time,
  input  logic [VB_W-1:0]  vblank,
  output rg_state_e        state,
  output logic [CNT_W-1:0] slot_cnt,
  output logic [ROW_W-1:0] row_idx,
  output logic             frame_wrap
);

  localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
  localparam logic [ROW_W-1:0] R_ONE = ROW_W'(1);
  localparam logic [VB_W-1:0]  V_ONE = VB_W'(1);

  rg_state_e        nxt_state;
  logic [CNT_W-1:0] nxt_cnt;
  logic [ROW_W-1:0] nxt_row;
  logic [VB_W-1:0]  vrow, nxt_vrow;
  logic             wrap;

  always_comb begin
    nxt_state = state;
    nxt_cnt   = slot_cnt + C_ONE;
    nxt_row   = row_idx;
    nxt_vrow  = vrow;
    wrap      = 1'b0;
    case (state)
      ST_FSTART: if (slot_cnt == fb_len - C_ONE) begin
        nxt_state = ST_ACT;
        nxt_cnt   = '0;
        nxt_row   = '0;
      end
      ST_ACT: if (slot_cnt == act_len - C_ONE) begin
        nxt_cnt = '0;
        if (row_idx == n_rows - R_ONE)  nxt_state = ST_FEND;
        else if (hb_len == '0)          nxt_row   = row_idx + R_ONE;
        else                            nxt_state = ST_HBLK;
      end
      ST_HBLK: if (slot_cnt == hb_len - C_ONE) begin
        nxt_state = ST_ACT;
        nxt_cnt   = '0;
        nxt_row   = row_idx + R_ONE;
      end
      ST_FEND: if (slot_cnt == fb_len - C_ONE) begin
        nxt_cnt  = '0;
        nxt_vrow = '0;
        if (vblank == '0) begin
          nxt_state = ST_FSTART;
          wrap      = 1'b1;
        end else begin
          nxt_state = ST_VBLK;
        end
      end
      ST_VBLK: if (slot_cnt == row_time - C_ONE) begin
        nxt_cnt = '0;
        if (vrow == vblank - V_ONE) begin
          nxt_state = ST_FSTART;
          wrap      = 1'b1;
        end else begin
          nxt_vrow = vrow + V_ONE;
        end
      end
      default: begin
        nxt_state = ST_FSTART;
        nxt_cnt   = '0;
      end
    endcase
  end

  assign frame_wrap = step & wrap;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_FSTART;
      slot_cnt <= '0;
      row_idx  <= '0;
      vrow     <= '0;
    end else if (step) begin
      state    <= nxt_state;
      slot_cnt <= nxt_cnt;
      row_idx  <= nxt_row;
      vrow     <= nxt_vrow;
    end
  end

  AST_ROW_IDX_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ACT) |-> (row_idx < n_rows)); // R3
  AST_WRAP_STARTS_FRAME: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> (state == ST_FSTART && slot_cnt == '0)); // R10

endmodule

// File: rtl/rg_axis.sv
module rg_axis #(
  parameter int W     = 9,
  parameter int BLACK = 6,
  parameter int LIMIT = 496
) (
  input  logic [W-1:0] idx,
  input  logic [W-1:0] count,
  input  logic [W-1:0] start,
  input  logic         mirror,
  input  logic         skip,
  output logic [W-1:0] addr
);

  localparam int SW = W + 2;
  localparam logic [SW-1:0] TOP = SW'(LIMIT - 1);

  logic [W-1:0]  k;
  logic [SW-1:0] off, sum;

  always_comb begin
    k    = mirror ? (count - W'(1) - idx) : idx;
    off  = skip ? (SW'(k) << 1) : SW'(k);
    sum  = SW'(BLACK) + SW'(start) + off;
    addr = (sum > TOP) ? W'(LIMIT - 1) : sum[W-1:0];
  end

endmodule

// File: rtl/pix_raster_gen.sv
module pix_raster_gen
  import rg_pkg::*;
#(
  parameter int ARRAY_ROWS = 496,
  parameter int ARRAY_COLS = 668,
  parameter int BLACK_ROWS = 6,
  parameter int BLACK_COLS = 18,
  parameter int ROW_W      = $clog2(ARRAY_ROWS),
  parameter int COL_W      = $clog2(ARRAY_COLS),
  parameter int HB_W       = 10,
  parameter int VB_W       = 10,
  parameter int DIV_W      = 4,
  parameter int DATA_W     = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ROW_W-1:0]  cfg_row_start,
  input  logic [COL_W-1:0]  cfg_col_start,
  input  logic [ROW_W-1:0]  cfg_height,
  input  logic [COL_W-1:0]  cfg_width,
  input  logic [HB_W-1:0]   cfg_hblank,
  input  logic [VB_W-1:0]   cfg_vblank,
  input  logic [DIV_W-1:0]  cfg_clk_div,
  input  logic [4:0]        cfg_mode,
  output logic              pix_clk,
  output logic              frame_valid,
  output logic              line_valid,
  output logic [ROW_W-1:0]  row_addr,
  output logic [COL_W-1:0]  col_addr,
  output logic [DATA_W-1:0] pix_data
);

  localparam int WMAX  = (COL_W + 1 > HB_W) ? COL_W + 1 : HB_W;
  localparam int CNT_W = ((WMAX > DIV_W + 2) ? WMAX : DIV_W + 2) + 2;
  localparam int SUM_W = ((ROW_W > COL_W) ? ROW_W : COL_W) + 1;

  rg_mode_t         in_mode, sh_mode;
  logic [ROW_W-1:0] sh_row_start, n_rows, row_idx, row_a;
  logic [COL_W-1:0] sh_col_start, n_cols, col_idx, col_a;
  logic [VB_W-1:0]  sh_vblank;
  logic [CNT_W-1:0] act_len, hb_len, fb_len, row_time, slot_cnt;
  rg_state_e        state;
  logic             frame_wrap, in_act;

  assign in_mode = rg_mode_t'(cfg_mode);

  rg_shadow #(
    .ROW_W(ROW_W), .COL_W(COL_W), .HB_W(HB_W), .VB_W(VB_W),
    .DIV_W(DIV_W), .CNT_W(CNT_W)
  ) u_shadow (
    .clk(clk), .load(rst | frame_wrap),
    .in_row_start(cfg_row_start), .in_col_start(cfg_col_start),
    .in_height(cfg_height), .in_width(cfg_width),
    .in_hblank(cfg_hblank), .in_vblank(cfg_vblank),
    .in_div(cfg_clk_div), .in_mode(in_mode),
    .sh_row_start(sh_row_start), .sh_col_start(sh_col_start),
    .sh_vblank(sh_vblank), .sh_mode(sh_mode),
    .n_rows(n_rows), .n_cols(n_cols), .act_len(act_len),
    .hb_len(hb_len), .fb_len(fb_len), .row_time(row_time)
  );

  rg_seq #(.ROW_W(ROW_W), .VB_W(VB_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .step(pix_clk),
    .n_rows(n_rows), .act_len(act_len), .hb_len(hb_len),
    .fb_len(fb_len), .row_time(row_time), .vblank(sh_vblank),
    .state(state), .slot_cnt(slot_cnt), .row_idx(row_idx),
    .frame_wrap(frame_wrap)
  );

  // Repeat mode spends two slots on each column index
  assign col_idx = COL_W'(sh_mode.zoom ? (slot_cnt >> 1) : slot_cnt);

  rg_axis #(.W(ROW_W), .BLACK(BLACK_ROWS), .LIMIT(ARRAY_ROWS)) u_row_axis (
    .idx(row_idx), .count(n_rows), .start(sh_row_start),
    .mirror(sh_mode.row_mirror), .skip(sh_mode.row_skip), .addr(row_a)
  );

  rg_axis #(.W(COL_W), .BLACK(BLACK_COLS), .LIMIT(ARRAY_COLS)) u_col_axis (
    .idx(col_idx), .count(n_cols), .start(sh_col_start),
    .mirror(sh_mode.col_mirror), .skip(sh_mode.col_skip), .addr(col_a)
  );

  assign in_act = (state == ST_ACT);

  // Outputs update on the edge where pix_clk drops; it rises one clock later
  always_ff @(posedge clk) begin
    if (rst) begin
      pix_clk     <= 1'b1;
      frame_valid <= 1'b0;
      line_valid  <= 1'b0;
      row_addr    <= '0;
      col_addr    <= '0;
      pix_data    <= '0;
    end else begin
      pix_clk <= ~pix_clk;
      if (pix_clk) begin
        frame_valid <= (state != ST_VBLK);
        line_valid  <= in_act;
        row_addr    <= in_act ? row_a : '0;
        col_addr    <= in_act ? col_a : '0;
        pix_data    <= in_act ? DATA_W'(SUM_W'(row_a) + SUM_W'(col_a)) : '0;
      end
    end
  end

  AST_PCLK_TOGGLES: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pix_clk != $past(pix_clk))); // R2
  AST_HOLD_WHILE_PCLK_HIGH: assert property (@(posedge clk) disable iff (rst)
    pix_clk |-> ($stable(frame_valid) && $stable(line_valid) &&
                 $stable(row_addr) && $stable(col_addr) && $stable(pix_data))); // R2
  AST_LV_INSIDE_FV: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> frame_valid); // R3
  AST_ROW_IN_ARRAY: assert property (@(posedge clk) disable iff (rst)
    row_addr <= ROW_W'(ARRAY_ROWS - 1)); // R9
  AST_COL_IN_ARRAY: assert property (@(posedge clk) disable iff (rst)
    col_addr <= COL_W'(ARRAY_COLS - 1)); // R9
  AST_IDLE_OUTPUTS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !line_valid |-> (pix_data == '0 && row_addr == '0 && col_addr == '0)); // R11

endmodule

// File: tb/pix_raster_gen_test.sv
`timescale 1ns/1ps
module pix_raster_gen_test;

  localparam int AR = 30, AC = 40, BR = 2, BC = 4;
  localparam int ROW_W = 5, COL_W = 6, HB_W = 5, VB_W = 3, DIV_W = 3, DATA_W = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [ROW_W-1:0]  rs, h;
  logic [COL_W-1:0]  cs, w;
  logic [HB_W-1:0]   hb;
  logic [VB_W-1:0]   vb;
  logic [DIV_W-1:0]  dv;
  logic [4:0]        md;
  logic              pix_clk, frame_valid, line_valid;
  logic [ROW_W-1:0]  row_addr;
  logic [COL_W-1:0]  col_addr;
  logic [DATA_W-1:0] pix_data;

  always #10 clk = ~clk;

  pix_raster_gen #(
    .ARRAY_ROWS(AR), .ARRAY_COLS(AC), .BLACK_ROWS(BR), .BLACK_COLS(BC),
    .ROW_W(ROW_W), .COL_W(COL_W), .HB_W(HB_W), .VB_W(VB_W),
    .DIV_W(DIV_W), .DATA_W(DATA_W)
  ) uut (
    .clk(clk), .rst(rst),
    .cfg_row_start(rs), .cfg_col_start(cs), .cfg_height(h), .cfg_width(w),
    .cfg_hblank(hb), .cfg_vblank(vb), .cfg_clk_div(dv), .cfg_mode(md),
    .pix_clk(pix_clk), .frame_valid(frame_valid), .line_valid(line_valid),
    .row_addr(row_addr), .col_addr(col_addr), .pix_data(pix_data)
  );

  typedef struct packed {
    logic fv; logic lv; logic [15:0] row; logic [15:0] col; logic [15:0] data;
  } slot_t;

  slot_t exp_q[$];
  slot_t prev_obs;
  int    n_checks = 0, n_fail = 0, frames = 0;
  string cur_req = "R4";
  logic  running = 1'b0;
  logic  prev_pclk = 1'b1;
  logic  done = 1'b0;

  task automatic check(bit ok, string req, string what, int act, int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int clampv(int v, int lim);
    return (v > lim - 1) ? lim - 1 : v;
  endfunction

  task automatic push_blank(int n, bit fv);
    for (int i = 0; i < n; i++) exp_q.push_back('{fv, 1'b0, 16'd0, 16'd0, 16'd0});
  endtask

  // Reference frame from the settings on the inputs at frame start (R3..R11)
  task automatic build_frame();
    int nr, nc, alen, fb, rk, row, p, ck, col;
    nr = md[2] ? int'(h) / 2 : int'(h);
    if (nr == 0) nr = 1;
    nc = md[3] ? int'(w) / 2 : int'(w);
    if (nc == 0) nc = 1;
    alen = md[4] ? 2 * nc : nc;
    fb = 3 * (int'(dv) + 2);
    push_blank(fb, 1'b1);
    for (int r = 0; r < nr; r++) begin
      rk  = md[0] ? nr - 1 - r : r;
      row = clampv(BR + int'(rs) + (md[2] ? 2 * rk : rk), AR);
      for (int s = 0; s < alen; s++) begin
        p   = md[4] ? s / 2 : s;
        ck  = md[1] ? nc - 1 - p : p;
        col = clampv(BC + int'(cs) + (md[3] ? 2 * ck : ck), AC);
        exp_q.push_back('{1'b1, 1'b1, 16'(row), 16'(col),
                          16'((row + col) % (1 << DATA_W))});
      end
      if (r < nr - 1) push_blank(int'(hb), 1'b1);
    end
    push_blank(fb, 1'b1);
    push_blank(int'(vb) * (alen + int'(hb)), 1'b0);
  endtask

  always @(negedge clk) begin
    slot_t e, obs;
    if (running && !done) begin
      obs = '{frame_valid, line_valid, 16'(row_addr), 16'(col_addr), 16'(pix_data)};
      check(pix_clk != prev_pclk, "R2", "pix_clk toggle", pix_clk, !prev_pclk);
      if (pix_clk) begin
        check(obs == prev_obs, "R2", "hold while pix_clk high", obs.col, prev_obs.col);
        if (exp_q.size() == 0) begin
          build_frame();
          frames++;
        end
        e = exp_q.pop_front();
        check(obs.fv == e.fv, "R3", "frame_valid", obs.fv, e.fv);
        check(obs.lv == e.lv, "R3", "line_valid", obs.lv, e.lv);
        check(obs.row == e.row, cur_req, "row_addr", obs.row, e.row);
        check(obs.col == e.col, cur_req, "col_addr", obs.col, e.col);
        check(obs.data == e.data, "R11", "pix_data", obs.data, e.data);
      end
      prev_pclk = pix_clk;
      prev_obs  = obs;
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic set_cfg(int a_rs, int a_cs, int a_h, int a_w, int a_hb, int a_vb,
                         int a_dv, logic [4:0] a_md, string req, bit wait_frames);
    int f0;
    @(negedge clk);
    while (!line_valid) @(negedge clk);
    rs = ROW_W'(a_rs); cs = COL_W'(a_cs); h = ROW_W'(a_h); w = COL_W'(a_w);
    hb = HB_W'(a_hb); vb = VB_W'(a_vb); dv = DIV_W'(a_dv); md = a_md;
    cur_req = req;
    f0 = frames;
    if (wait_frames) while (frames < f0 + 2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL R3 watchdog expired actual=%0d expected=%0d", frames, 0);
    finish_run();
  end

  initial begin
    rs = 1; cs = 2; h = 6; w = 8; hb = 3; vb = 2; dv = 0; md = 5'b00000;
    repeat (5) @(negedge clk);
    // R1: reset state
    check(pix_clk == 1'b1, "R1", "pix_clk in reset", pix_clk, 1);
    check(frame_valid == 1'b0, "R1", "frame_valid in reset", frame_valid, 0);
    check(line_valid == 1'b0, "R1", "line_valid in reset", line_valid, 0);
    check(row_addr == '0 && col_addr == '0, "R1", "addresses in reset", row_addr, 0);
    check(pix_data == '0, "R1", "pix_data in reset", pix_data, 0);
    rst = 1'b0;
    @(posedge clk);
    prev_pclk = 1'b1;
    prev_obs  = '0;
    running   = 1'b1;
    while (frames < 2) @(negedge clk);
    // R3: no horizontal or vertical blank, divider 1
    set_cfg(0, 0, 5, 7, 0, 0, 1, 5'b00000, "R3", 1'b1);
    // R5: both skips with odd sizes
    set_cfg(3, 1, 7, 9, 2, 1, 0, 5'b01100, "R5", 1'b1);
    // R6: pixel repeat
    set_cfg(2, 3, 4, 5, 2, 1, 0, 5'b10000, "R6", 1'b1);
    // R7: row mirror
    set_cfg(1, 0, 6, 6, 1, 1, 0, 5'b00001, "R7", 1'b1);
    // R8: column mirror with column skip
    set_cfg(0, 5, 5, 8, 2, 1, 2, 5'b01010, "R8", 1'b1);
    // R7 and R8 with repeat
    set_cfg(0, 0, 4, 6, 1, 1, 0, 5'b11011, "R8", 1'b1);
    // R9: window past both array edges
    set_cfg(25, 33, 8, 6, 2, 1, 0, 5'b00000, "R9", 1'b1);
    set_cfg(20, 30, 8, 10, 1, 1, 0, 5'b00011, "R9", 1'b1);
    // R5: counts that halve to zero become one
    set_cfg(1, 1, 0, 1, 2, 1, 0, 5'b01100, "R5", 1'b1);
    // R3: largest divider
    set_cfg(0, 0, 3, 4, 4, 2, 7, 5'b00000, "R3", 1'b1);
    // R10: two changes inside one frame, only the last is taken at frame start
    set_cfg(2, 2, 6, 6, 2, 1, 1, 5'b00100, "R10", 1'b0);
    @(negedge clk);
    while (line_valid) @(negedge clk);
    set_cfg(1, 3, 4, 5, 1, 1, 0, 5'b10010, "R10", 1'b1);
    finish_run();
  end

endmodule